// File: doc/BRIEF.md
# Successive Halving Charge Readout Controller

This block sequences an integrate-and-compare readout converter that a group of neuron lanes share. For each conversion it first switches the amplifiers into open-loop compare mode and captures a sign decision per lane. It then runs one magnitude cycle per remaining output bit. Each magnitude cycle applies a reference charge step, then compares again. The step size halves from one magnitude cycle to the next. A single shared reference source supplies the steps, and the controller only picks which step level the source presents. Each lane decides for itself whether that step is added or subtracted. The choice comes from nothing but the comparison that lane latched one cycle earlier, so no residue amplifier and no per-lane multi-bit converter are needed.

Once the last magnitude bit is latched, the controller opens the path to the line registers for one cycle and presents each lane's signed result as a sign-magnitude word. One cycle later it raises a done strobe. The output width is chosen per conversion, from one bit (sign only) up to the build-time maximum.

Top module: `halving_readout_ctrl`

## Requirements
- R1: In reset and after it, amp_mode is hold (encoding 0), wr_en, done and every step_sub bit are 0, and wr_data is all zero.
- R2: The first clock cycle after an accepted start is a compare cycle (amp_mode 1). At its end each lane latches the inverse of its cmp_in as the sign bit. cmp_in 0 means positive charge, so the sign bit is 1 for positive.
- R3: For an effective width n, the cycles after the sign cycle follow this order: n-1 pairs of one integrate cycle (amp_mode 2) and then one compare cycle, one write cycle, and then idle. A conversion therefore holds exactly n compare cycles.
- R4: In the k-th integrate cycle of a conversion (k counted from 0), step_idx equals k. Index k selects a step of full scale divided by 2^(k+1), so each step is half of the one before.
- R5: During an integrate cycle, step_sub of a lane equals the inverse of that lane's cmp_in in the compare cycle just before it (1 = subtract, 0 = add). Outside integrate cycles every step_sub bit is 0.
- R6: When a lane's sign bit is 0, each of its magnitude bits is the inverse of the latched comparison. When the sign bit is 1, the latched comparisons are used unchanged.
- R7: wr_en is high for exactly one cycle: the cycle 2n after the start edge, with amp_mode hold. During that cycle, lane i's word sits in wr_data[i*NMAX +: NMAX]. Its sign bit is at position n-1, the magnitude bits sit below it with the first-decided bit at n-2, and all bits above n-1 are 0.
- R8: done is high for exactly the one cycle that follows the wr_en cycle.
- R9: width_cfg is sampled only when a start is accepted. A value of 0 is treated as 1, and a value above NMAX is treated as NMAX.
- R10: A start asserted while a conversion is in progress (including its write cycle) is ignored. The running conversion keeps its length and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion when idle |
| width_cfg | input | CFGW | Requested output width n in bits, sign included |
| cmp_in | input | NEUR | Per-lane comparator output, 0 when the integrated charge is positive or zero |
| amp_mode | output | 2 | Amplifier mode: 0 hold, 1 compare, 2 integrate with reference step |
| step_idx | output | IDXW | Shared reference step level index during integrate cycles |
| step_sub | output | NEUR | Per-lane step polarity, 1 subtract, 0 add |
| wr_en | output | 1 | Line register write enable, one cycle |
| wr_data | output | NEUR*NMAX | Per-lane sign-magnitude results |
| done | output | 1 | Conversion finished strobe |

## Verification
Several properties are checked on every cycle. Every integrate cycle is followed by a compare. The polarity of every step equals the inverse of the comparison one cycle earlier, and polarity stays quiet outside integrate cycles. The step index starts at zero and climbs by one between consecutive integrate cycles. The write strobe is a single cycle with the amplifiers on hold, and done follows it. Only the bench scenarios can show the converted codes themselves: the bench drives a residual model and compares each result against an ideal threshold count. The same scenarios cover magnitude inversion for negative inputs, clipping beyond full scale, the clamping of width_cfg, and starts issued while the controller is busy.

// File: rtl/hro_pkg.sv
package hro_pkg;

  // Amplifier configuration presented to the analog lanes.
  typedef enum logic [1:0] {
    AMP_HOLD      = 2'd0,
    AMP_COMPARE   = 2'd1,
    AMP_INTEGRATE = 2'd2
  } amp_mode_e;

  // Conversion sequencer states.
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_SIGN  = 3'd1,
    SQ_STEP  = 3'd2,
    SQ_CMP   = 3'd3,
    SQ_WRITE = 3'd4
  } seq_state_e;

endpackage

// File: rtl/hro_sequencer.sv
module hro_sequencer
  import hro_pkg::*;
#(
  parameter int NMAX = 8,
  parameter int CFGW = 4,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CFGW-1:0] width_cfg,
  output logic [1:0]      amp_mode,
  output logic [IDXW-1:0] step_idx,
  output logic            step_on,
  output logic            sign_cap,
  output logic            mag_cap,
  output logic            clear,
  output logic            wr_en,
  output logic            done,
  output logic [CFGW-1:0] width_q
);

  seq_state_e      state_q;
  amp_mode_e       amp_q;
  logic [CFGW-1:0] eff_w;
  logic [IDXW-1:0] last_idx_d;
  logic [IDXW-1:0] last_idx_q;

  // Clamp the requested width into 1..NMAX.
  always_comb begin
    if (width_cfg == '0)
      eff_w = CFGW'(1);
    else if (width_cfg > CFGW'(NMAX))
      eff_w = CFGW'(NMAX);
    else
      eff_w = width_cfg;
    last_idx_d = IDXW'(eff_w - CFGW'(2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      amp_q      <= AMP_HOLD;
      step_idx   <= '0;
      step_on    <= 1'b0;
      wr_en      <= 1'b0;
      done       <= 1'b0;
      width_q    <= CFGW'(1);
      last_idx_q <= '0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q    <= SQ_SIGN;
            amp_q      <= AMP_COMPARE;
            width_q    <= eff_w;
            last_idx_q <= last_idx_d;
          end
        end
        SQ_SIGN: begin
          if (width_q == CFGW'(1)) begin
            state_q <= SQ_WRITE;
            amp_q   <= AMP_HOLD;
            wr_en   <= 1'b1;
          end else begin
            state_q  <= SQ_STEP;
            amp_q    <= AMP_INTEGRATE;
            step_idx <= '0;
            step_on  <= 1'b1;
          end
        end
        SQ_STEP: begin
          state_q <= SQ_CMP;
          amp_q   <= AMP_COMPARE;
          step_on <= 1'b0;
        end
        SQ_CMP: begin
          if (step_idx == last_idx_q) begin
            state_q <= SQ_WRITE;
            amp_q   <= AMP_HOLD;
            wr_en   <= 1'b1;
          end else begin
            state_q  <= SQ_STEP;
            amp_q    <= AMP_INTEGRATE;
            step_idx <= step_idx + IDXW'(1);
            step_on  <= 1'b1;
          end
        end
        SQ_WRITE: begin
          state_q <= SQ_IDLE;
          done    <= 1'b1;
        end
        default: begin
          state_q <= SQ_IDLE;
          amp_q   <= AMP_HOLD;
        end
      endcase
    end
  end

  assign amp_mode = amp_q;
  assign sign_cap = (state_q == SQ_SIGN);
  assign mag_cap  = (state_q == SQ_CMP);
  assign clear    = (state_q == SQ_IDLE) && start;

endmodule

// File: rtl/hro_lane.sv
module hro_lane #(
  parameter int MAGW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            sign_cap,
  input  logic            mag_cap,
  input  logic            cmp_raw,
  output logic            polarity,
  output logic            sign_bit,
  output logic [MAGW-1:0] mag_raw
);

  logic            decided;
  logic [MAGW:0]   shifted;

  // Comparator pulls low for positive charge; the latch stores positive as 1.
  assign decided = ~cmp_raw;
  assign shifted = {mag_raw, decided};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      polarity <= 1'b0;
      sign_bit <= 1'b0;
      mag_raw  <= '0;
    end else if (sign_cap) begin
      polarity <= decided;
      sign_bit <= decided;
    end else if (mag_cap) begin
      polarity <= decided;
      mag_raw  <= shifted[MAGW-1:0];
    end
  end

endmodule

// File: rtl/hro_packer.sv
module hro_packer #(
  parameter int NEUR = 4,
  parameter int NMAX = 8,
  parameter int CFGW = 4,
  parameter int MAGW = 7
) (
  input  logic [CFGW-1:0]      width_q,
  input  logic [NEUR-1:0]      sign_bits,
  input  logic [NEUR*MAGW-1:0] mags,
  output logic [NEUR*NMAX-1:0] words
);

  for (genvar g = 0; g < NEUR; g++) begin : g_word
    logic [MAGW-1:0] raw;
    logic [MAGW-1:0] fixed;
    logic [NMAX-1:0] word;

    assign raw   = mags[g*MAGW +: MAGW];
    // A negative lane saw every decision mirrored; undo that here.
    assign fixed = sign_bits[g] ? raw : ~raw;

    always_comb begin
      for (int b = 0; b < NMAX; b++) begin
        if (b < int'(width_q) - 1)
          word[b] = (b < MAGW) ? fixed[b] : 1'b0;
        else if (b == int'(width_q) - 1)
          word[b] = sign_bits[g];
        else
          word[b] = 1'b0;
      end
    end

    assign words[g*NMAX +: NMAX] = word;
  end

endmodule

// File: rtl/halving_readout_ctrl.sv
module halving_readout_ctrl #(
  parameter  int NEUR = 4,
  parameter  int NMAX = 8,
  localparam int CFGW = $clog2(NMAX + 1),
  localparam int IDXW = (NMAX > 2) ? $clog2(NMAX - 1) : 1,
  localparam int MAGW = (NMAX > 1) ? NMAX - 1 : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CFGW-1:0]      width_cfg,
  input  logic [NEUR-1:0]      cmp_in,
  output logic [1:0]           amp_mode,
  output logic [IDXW-1:0]      step_idx,
  output logic [NEUR-1:0]      step_sub,
  output logic                 wr_en,
  output logic [NEUR*NMAX-1:0] wr_data,
  output logic                 done
);

  logic            step_on;
  logic            sign_cap;
  logic            mag_cap;
  logic            clear;
  logic [CFGW-1:0] width_q;
  logic [NEUR-1:0] polarity;
  logic [NEUR-1:0] sign_bits;
  logic [NEUR*MAGW-1:0] mags;

  hro_sequencer #(
    .NMAX(NMAX),
    .CFGW(CFGW),
    .IDXW(IDXW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .width_cfg(width_cfg),
    .amp_mode (amp_mode),
    .step_idx (step_idx),
    .step_on  (step_on),
    .sign_cap (sign_cap),
    .mag_cap  (mag_cap),
    .clear    (clear),
    .wr_en    (wr_en),
    .done     (done),
    .width_q  (width_q)
  );

  for (genvar g = 0; g < NEUR; g++) begin : g_lane
    hro_lane #(
      .MAGW(MAGW)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .clear   (clear),
      .sign_cap(sign_cap),
      .mag_cap (mag_cap),
      .cmp_raw (cmp_in[g]),
      .polarity(polarity[g]),
      .sign_bit(sign_bits[g]),
      .mag_raw (mags[g*MAGW +: MAGW])
    );
  end

  // Polarity only reaches the shared step switches while a step is applied.
  assign step_sub = step_on ? polarity : '0;

  hro_packer #(
    .NEUR(NEUR),
    .NMAX(NMAX),
    .CFGW(CFGW),
    .MAGW(MAGW)
  ) u_pack (
    .width_q  (width_q),
    .sign_bits(sign_bits),
    .mags     (mags),
    .words    (wr_data)
  );

endmodule

// File: rtl/hro_checker.sv
module hro_checker #(
  parameter int NEUR = 4,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NEUR-1:0] cmp_in,
  input logic [1:0]      amp_mode,
  input logic [IDXW-1:0] step_idx,
  input logic [NEUR-1:0] step_sub,
  input logic            wr_en,
  input logic            done
);

  a_r3_integrate_then_compare: assert property (@(posedge clk) disable iff (rst)
    (amp_mode == 2'd2) |=> (amp_mode == 2'd1));

  a_r5_polarity_from_latch: assert property (@(posedge clk) disable iff (rst)
    (amp_mode == 2'd2) |-> (step_sub == ~$past(cmp_in)));

  a_r5_polarity_quiet: assert property (@(posedge clk) disable iff (rst)
    (amp_mode != 2'd2) |-> (step_sub == '0));

  a_r4_first_index: assert property (@(posedge clk) disable iff (rst)
    (amp_mode == 2'd2 && $past(amp_mode) == 2'd1 && $past(amp_mode, 2) != 2'd2)
      |-> (step_idx == '0));

  a_r4_index_advances: assert property (@(posedge clk) disable iff (rst)
    (amp_mode == 2'd2 && $past(amp_mode, 2) == 2'd2)
      |-> (step_idx == IDXW'($past(step_idx, 2) + IDXW'(1))));

  a_r7_write_single: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r7_write_on_hold: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (amp_mode == 2'd0));

  a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> done);

  a_r8_done_only_after_write: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_en));

endmodule

bind halving_readout_ctrl hro_checker #(
  .NEUR(NEUR),
  .IDXW(IDXW)
) u_hro_chk (
  .clk     (clk),
  .rst     (rst),
  .cmp_in  (cmp_in),
  .amp_mode(amp_mode),
  .step_idx(step_idx),
  .step_sub(step_sub),
  .wr_en   (wr_en),
  .done    (done)
);

// File: tb/halving_readout_ctrl_bench.sv
module halving_readout_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NEUR = 4;
  localparam int NMAX = 8;
  localparam int CFGW = 4;
  localparam int IDXW = 3;
  localparam int FS   = 4096;
  localparam int WDOG = 150000;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic [CFGW-1:0]      width_cfg = '0;
  logic [NEUR-1:0]      cmp_in;
  logic [1:0]           amp_mode;
  logic [IDXW-1:0]      step_idx;
  logic [NEUR-1:0]      step_sub;
  logic                 wr_en;
  logic [NEUR*NMAX-1:0] wr_data;
  logic                 done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Residual charge model of each lane's integrator.
  int acc      [NEUR];
  int load_val [NEUR];
  int xv       [NEUR];
  logic load_req = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  halving_readout_ctrl #(.NEUR(NEUR), .NMAX(NMAX)) u_halving_readout_ctrl (
    .clk(clk), .rst(rst), .start(start), .width_cfg(width_cfg), .cmp_in(cmp_in),
    .amp_mode(amp_mode), .step_idx(step_idx), .step_sub(step_sub),
    .wr_en(wr_en), .wr_data(wr_data), .done(done)
  );

  always @(posedge clk) begin
    for (int i = 0; i < NEUR; i++) begin
      if (load_req)
        acc[i] <= load_val[i];
      else if (amp_mode == 2'd2)
        acc[i] <= step_sub[i] ? acc[i] - (FS >>> (int'(step_idx) + 1))
                              : acc[i] + (FS >>> (int'(step_idx) + 1));
    end
  end

  always_comb begin
    for (int i = 0; i < NEUR; i++) cmp_in[i] = (acc[i] < 0);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp_w(input int cfg);
    if (cfg == 0) return 1;
    if (cfg > NMAX) return NMAX;
    return cfg;
  endfunction

  // Ideal conversion: count the decision thresholds the residual lies beyond.
  function automatic int ref_word(input int x, input int n);
    int k   = n - 1;
    int lsb = FS >> k;
    int mag = 0;
    for (int j = 1; j < (1 << k); j++) begin
      if (x >= 0 && x >= j * lsb) mag++;
      if (x < 0 && x < -j * lsb) mag++;
    end
    return ((x >= 0) ? (1 << (n - 1)) : 0) | mag;
  endfunction

  task automatic run_conv(input int cfg, input bit inject);
    int  eff = clamp_w(cfg);
    int  k   = eff - 1;
    int  n_cmp = 0;
    bit  seq_ok = 1, idx_ok = 1, sub_ok = 1, wr_ok = 1, dn_ok = 1;
    int  exp_amp;
    @(negedge clk);
    for (int i = 0; i < NEUR; i++) load_val[i] = xv[i];
    load_req  = 1'b1;
    start     = 1'b1;
    width_cfg = CFGW'(cfg);
    @(negedge clk);
    load_req = 1'b0;
    start    = 1'b0;
    for (int j = 1; j <= 2 * eff + 1; j++) begin
      if (j == 1) exp_amp = 1;
      else if (j <= 2 * k + 1) exp_amp = (j % 2 == 0) ? 2 : 1;
      else exp_amp = 0;
      if (int'(amp_mode) != exp_amp) seq_ok = 0;
      if (amp_mode == 2'd1) n_cmp++;
      if (exp_amp == 2) begin
        if (int'(step_idx) != j / 2 - 1) idx_ok = 0;
        for (int i = 0; i < NEUR; i++)
          if (step_sub[i] != (acc[i] >= 0)) sub_ok = 0;
      end else if (step_sub != '0) sub_ok = 0;
      if (wr_en != (j == 2 * eff)) wr_ok = 0;
      if (done != (j == 2 * eff + 1)) dn_ok = 0;
      if (j == 2 * eff) begin
        for (int i = 0; i < NEUR; i++) begin
          int got = int'(wr_data[i*NMAX +: NMAX]);
          int exp = ref_word(xv[i], eff);
          string rq = (cfg != eff) ? "R9" : ((xv[i] < 0) ? "R6" : "R2");
          check(got == exp, rq, $sformatf("lane %0d word x=%0d n=%0d", i, xv[i], eff), got, exp);
        end
      end
      if (inject && j == 2) begin
        start     = 1'b1;
        width_cfg = CFGW'((cfg % NMAX) + 1);
      end
      if (inject && j == 3) start = 1'b0;
      if (j < 2 * eff + 1) @(negedge clk);
    end
    check(seq_ok && n_cmp == eff, inject ? "R10" : "R3", "mode sequence / compare count", n_cmp, eff);
    check(idx_ok, "R4", "step index per integrate cycle", idx_ok, 1);
    check(sub_ok, "R5", "step polarity from previous compare", sub_ok, 1);
    check(wr_ok, "R7", "write strobe timing", wr_ok, 1);
    check(dn_ok, "R8", "done strobe timing", dn_ok, 1);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", WDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    for (int i = 0; i < NEUR; i++) begin acc[i] = 0; load_val[i] = 0; xv[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(amp_mode == 2'd0 && !wr_en && !done && step_sub == '0 && wr_data == '0,
          "R1", "state during reset", {amp_mode, wr_en, done, step_sub}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(amp_mode == 2'd0 && !wr_en && !done && step_sub == '0 && wr_data == '0,
          "R1", "state after reset", {amp_mode, wr_en, done, step_sub}, 0);

    // Directed corners: zero, sign only, thresholds, clipping.
    xv[0] = 0;  xv[1] = -1;  xv[2] = 5;  xv[3] = -FS;
    run_conv(1, 0);
    xv[0] = FS + 100; xv[1] = -FS - 100; xv[2] = 2048; xv[3] = -2048;
    run_conv(8, 0);
    xv[0] = 31; xv[1] = 32; xv[2] = -32; xv[3] = -33;
    run_conv(8, 0);
    xv[0] = 0; xv[1] = -1; xv[2] = 1023; xv[3] = -1025;
    run_conv(3, 0);
    // R9: out-of-range widths
    run_conv(0, 0);
    run_conv(13, 0);
    // R10: start while busy
    xv[0] = 777; xv[1] = -1500; xv[2] = 3000; xv[3] = -4000;
    run_conv(5, 1);
    run_conv(1, 1);

    for (int t = 0; t < 300; t++) begin
      int cfg;
      if (t % 25 == 0) cfg = 0;
      else if (t % 25 == 1) cfg = 9 + int'($urandom_range(0, 6));
      else cfg = int'($urandom_range(1, NMAX));
      for (int i = 0; i < NEUR; i++)
        xv[i] = int'($urandom_range(0, 2 * FS + 400)) - FS - 200;
      run_conv(cfg, (t % 17) == 3);
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule